// File: doc/BRIEF.md
# Multi-Dialect Host Bus Register Front End

This block connects an 8-bit host processor to an internal register port. A single set of host pins can carry five bus dialects. The first is separate active-low read and write strobes. The second is a common data strobe with a read/not-write level. Both of these come in two forms: one with a dedicated 3-bit address bus and one where AD5..AD0 are multiplexed onto the data lines. The fifth dialect is an EPP-style cycle with an address strobe and a wait handshake. The block works out the dialect once after reset from the static levels on the control and address pins, and keeps it until the next reset.

Every host pin passes through a multi-stage synchroniser into the core clock domain. Each host strobe produces exactly one registered pulse on the internal port: a read enable or a write enable, with the address and write data. Read data comes back over the data pins together with an output enable. In EPP mode the A0 pin becomes the wait output. That output stays undriven until the host first pulls the address strobe low.

Top module: `hbus_front`

## Requirements
- R1: While reset is held and after it is released, reg_we, reg_re, data_oe and wait_oe are 0, and mode_valid is 0 until detection has run.
- R2: DETECT_DLY cycles after reset is released, the synchronised pins are decoded with this priority into mode_o. First: A2=1, A1=1 and cs_n=0 gives 5 (EPP). Second: ale=1 gives 1 (separate strobes, dedicated address) when cfg_common=0 and 3 (common strobe, dedicated address) when cfg_common=1. Third: A2=0, A1=1, A0=1 gives 2 (separate strobes, multiplexed). Fourth: A2=0, A1=1, A0=0 gives 4 (common strobe, multiplexed). Anything else gives 0, with mode_valid left at 0 and no register access.
- R3: In separate-strobe modes, a low on wr_n together with a low on cs_n gives one reg_we pulse after the strobe is released. The pulse carries the data and address that were present while the strobe was low.
- R4: A read strobe gives one reg_re pulse after its leading edge. After that, data_oe is 1 and data_o holds the register read data until the strobe is released, when data_oe returns to 0.
- R5: In common-strobe modes, a low on rd_n with cs_n low is the data strobe, and wr_n gives the direction (1 = read, 0 = write). A write is issued after the data strobe is released.
- R6: In multiplexed modes, the falling edge of ale latches din[5:0] as the register address for the accesses that follow. In dedicated modes the address is {3'b000, a_i[2:0]}.
- R7: With cs_n high, no strobe causes an access in any mode. In EPP mode this means cs_n high blocks the data strobe.
- R8: In EPP mode, ale low with wr_n low is an address write that latches din[5:0]. ale low with wr_n high (an address read) leaves the address unchanged.
- R9: In EPP mode, a data strobe (rd_n low, wr_n giving direction) issues its read or write on the strobe's leading edge.
- R10: In EPP mode, wait_oe stays 0 until the first falling edge of ale and is then 1 until reset. wait_o goes to 1 once an access has been issued and returns to 0 when the strobes are high again.
- R11: Each strobe gives exactly one access pulse, and reg_we and reg_re are never high together.
- R12: Once detection is done, changes on the pins do not change mode_o or mode_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_common | input | 1 | Selects the common strobe for dedicated-address modes |
| ale_i | input | 1 | ALE / AS / EPP address strobe (active low in EPP) |
| a_i | input | 3 | Dedicated address pins and detection straps |
| rd_n_i | input | 1 | Read strobe / data strobe |
| wr_n_i | input | 1 | Write strobe / read-not-write direction |
| cs_n_i | input | 1 | Chip select, active low |
| din | input | 8 | Host data / multiplexed address input |
| data_o | output | 8 | Read data to the host |
| data_oe | output | 1 | Data pin output enable |
| wait_o | output | 1 | EPP wait level on the A0 pin |
| wait_oe | output | 1 | A0 output enable |
| mode_o | output | 3 | Detected dialect code |
| mode_valid | output | 1 | A dialect was recognised |
| reg_addr | output | 6 | Register address |
| reg_wdata | output | 8 | Register write data |
| reg_we | output | 1 | Register write pulse |
| reg_re | output | 1 | Register read pulse |
| reg_rdata | input | 8 | Register read data, valid during reg_re |

## Verification
The hardest state to reach is the EPP wait pin before its first address strobe. To get there, the host must complete a full data transfer that raises the wait level while the pin is still undriven. The stimulus therefore runs an EPP data write right after detection and checks that wait_oe stays low. It then runs an address write, then an address read that must be ignored, and finally data cycles that must use the address from the earlier write. Each dialect is reached by resetting the block under a different set of pin straps.

// File: rtl/hbus_pkg.sv
package hbus_pkg;
  typedef enum logic [2:0] {
    HB_NONE    = 3'd0,
    HB_SEP_DED = 3'd1,
    HB_SEP_MUX = 3'd2,
    HB_COM_DED = 3'd3,
    HB_COM_MUX = 3'd4,
    HB_EPP     = 3'd5
  } hb_mode_e;
endpackage

// File: rtl/hbus_sync.sv
module hbus_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= '0;
      else     chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/hbus_detect.sv
module hbus_detect
  import hbus_pkg::*;
#(
  parameter int DETECT_DLY = 8
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     cfg_common,
  input  logic     s_ale,
  input  logic [2:0] s_a,
  input  logic     s_cs_n,
  output hb_mode_e mode,
  output logic     mode_valid
);
  localparam int CW = $clog2(DETECT_DLY + 1);

  logic [CW-1:0] cnt;
  logic          done;
  hb_mode_e      pick;

  always_comb begin
    if (s_a[2] && s_a[1] && !s_cs_n)       pick = HB_EPP;
    else if (s_ale)                         pick = cfg_common ? HB_COM_DED : HB_SEP_DED;
    else if (!s_a[2] && s_a[1] && s_a[0])  pick = HB_SEP_MUX;
    else if (!s_a[2] && s_a[1] && !s_a[0]) pick = HB_COM_MUX;
    else                                    pick = HB_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt        <= '0;
      done       <= 1'b0;
      mode       <= HB_NONE;
      mode_valid <= 1'b0;
    end else if (!done) begin
      if (cnt == CW'(DETECT_DLY - 1)) begin
        done       <= 1'b1;
        mode       <= pick;
        mode_valid <= (pick != HB_NONE);
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  p_mode_locked_r12: assert property (@(posedge clk) disable iff (rst)
    mode_valid |=> (mode_valid && $stable(mode)));
endmodule

// File: rtl/hbus_engine.sv
module hbus_engine
  import hbus_pkg::*;
#(
  parameter int DW   = 8,
  parameter int AW   = 6,
  parameter int DA_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  hb_mode_e        mode,
  input  logic            mode_valid,
  input  logic            s_ale,
  input  logic [DA_W-1:0] s_a,
  input  logic            s_rd_n,
  input  logic            s_wr_n,
  input  logic            s_cs_n,
  input  logic [DW-1:0]   s_d,
  input  logic [DW-1:0]   reg_rdata,
  output logic [AW-1:0]   reg_addr,
  output logic [DW-1:0]   reg_wdata,
  output logic            reg_we,
  output logic            reg_re,
  output logic [DW-1:0]   data_o,
  output logic            data_oe,
  output logic            wait_o,
  output logic            wait_oe
);
  logic is_sep, is_com, is_epp, is_mux, is_ded;
  logic cs_ok, rd_act, wr_act, as_act, ale_hi, ds_any;
  logic rd_q, wr_q, as_q, ale_q, ack_set;
  logic [AW-1:0] addr_lat, cur_addr, hold_addr;
  logic [DW-1:0] hold_data;

  always_comb begin
    is_sep = mode_valid && (mode == HB_SEP_DED || mode == HB_SEP_MUX);
    is_com = mode_valid && (mode == HB_COM_DED || mode == HB_COM_MUX);
    is_epp = mode_valid && (mode == HB_EPP);
    is_mux = mode_valid && (mode == HB_SEP_MUX || mode == HB_COM_MUX);
    is_ded = mode_valid && (mode == HB_SEP_DED || mode == HB_COM_DED);
    cs_ok  = !s_cs_n;
    rd_act = cs_ok && !s_rd_n && (is_sep || ((is_com || is_epp) && s_wr_n));
    wr_act = cs_ok && (is_sep ? !s_wr_n
                              : ((is_com || is_epp) && !s_rd_n && !s_wr_n));
    as_act = is_epp && !s_ale;
    ale_hi = is_mux && s_ale;
    ds_any = is_epp && cs_ok && !s_rd_n;
    cur_addr = is_ded ? AW'(s_a) : addr_lat;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_addr  <= '0;
      reg_wdata <= '0;
      reg_we    <= 1'b0;
      reg_re    <= 1'b0;
      data_o    <= '0;
      data_oe   <= 1'b0;
      wait_o    <= 1'b0;
      wait_oe   <= 1'b0;
      rd_q      <= 1'b0;
      wr_q      <= 1'b0;
      as_q      <= 1'b0;
      ale_q     <= 1'b0;
      ack_set   <= 1'b0;
      addr_lat  <= '0;
      hold_addr <= '0;
      hold_data <= '0;
    end else begin
      reg_we  <= 1'b0;
      reg_re  <= 1'b0;
      rd_q    <= rd_act;
      wr_q    <= wr_act;
      as_q    <= as_act;
      ale_q   <= ale_hi;
      ack_set <= is_epp && ((rd_act && !rd_q) || (wr_act && !wr_q) || (as_act && !as_q));

      // multiplexed address latch on the falling ALE/AS edge
      if (ale_q && !ale_hi) addr_lat <= s_d[AW-1:0];

      // EPP address strobe: first falling edge enables the wait driver
      if (as_act && !as_q) begin
        wait_oe <= 1'b1;
        if (!s_wr_n) addr_lat <= s_d[AW-1:0];
      end

      if (rd_act && !rd_q) begin
        reg_re   <= 1'b1;
        reg_addr <= cur_addr;
      end

      if (is_epp) begin
        if (wr_act && !wr_q) begin
          reg_we    <= 1'b1;
          reg_addr  <= cur_addr;
          reg_wdata <= s_d;
        end
      end else begin
        if (wr_act) begin
          hold_addr <= cur_addr;
          hold_data <= s_d;
        end
        if (!wr_act && wr_q) begin
          reg_we    <= 1'b1;
          reg_addr  <= hold_addr;
          reg_wdata <= hold_data;
        end
      end

      if (reg_re) begin
        data_o  <= reg_rdata;
        data_oe <= 1'b1;
      end else if (!rd_act) begin
        data_oe <= 1'b0;
      end

      if (!(ds_any || as_act)) wait_o <= 1'b0;
      else if (ack_set)        wait_o <= 1'b1;
    end
  end

  p_we_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    reg_we |=> !reg_we);
  p_re_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    reg_re |=> !reg_re);
  p_we_re_excl_r11: assert property (@(posedge clk) disable iff (rst)
    !(reg_we && reg_re));
  p_wait_oe_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    wait_oe |=> wait_oe);
  p_no_access_unlocked_r2: assert property (@(posedge clk) disable iff (rst)
    !mode_valid |-> (!reg_we && !reg_re));
  p_oe_after_read_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(data_oe) |-> $past(reg_re));
endmodule

// File: rtl/hbus_front.sv
module hbus_front
  import hbus_pkg::*;
#(
  parameter int DW          = 8,
  parameter int AW          = 6,
  parameter int DA_W        = 3,
  parameter int SYNC_STAGES = 2,
  parameter int DETECT_DLY  = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_common,
  input  logic            ale_i,
  input  logic [DA_W-1:0] a_i,
  input  logic            rd_n_i,
  input  logic            wr_n_i,
  input  logic            cs_n_i,
  input  logic [DW-1:0]   din,
  output logic [DW-1:0]   data_o,
  output logic            data_oe,
  output logic            wait_o,
  output logic            wait_oe,
  output logic [2:0]      mode_o,
  output logic            mode_valid,
  output logic [AW-1:0]   reg_addr,
  output logic [DW-1:0]   reg_wdata,
  output logic            reg_we,
  output logic            reg_re,
  input  logic [DW-1:0]   reg_rdata
);
  localparam int PW = 4 + DA_W + DW;

  logic [PW-1:0]   pins_raw, pins_s;
  logic            s_ale, s_rd_n, s_wr_n, s_cs_n;
  logic [DA_W-1:0] s_a;
  logic [DW-1:0]   s_d;
  hb_mode_e        mode;

  assign pins_raw = {ale_i, a_i, rd_n_i, wr_n_i, cs_n_i, din};
  assign {s_ale, s_a, s_rd_n, s_wr_n, s_cs_n, s_d} = pins_s;

  hbus_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pins_raw), .q(pins_s)
  );

  hbus_detect #(.DETECT_DLY(DETECT_DLY)) u_detect (
    .clk(clk), .rst(rst), .cfg_common(cfg_common),
    .s_ale(s_ale), .s_a(s_a[2:0]), .s_cs_n(s_cs_n),
    .mode(mode), .mode_valid(mode_valid)
  );

  hbus_engine #(.DW(DW), .AW(AW), .DA_W(DA_W)) u_engine (
    .clk(clk), .rst(rst), .mode(mode), .mode_valid(mode_valid),
    .s_ale(s_ale), .s_a(s_a), .s_rd_n(s_rd_n), .s_wr_n(s_wr_n),
    .s_cs_n(s_cs_n), .s_d(s_d), .reg_rdata(reg_rdata),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
    .reg_re(reg_re), .data_o(data_o), .data_oe(data_oe),
    .wait_o(wait_o), .wait_oe(wait_oe)
  );

  assign mode_o = mode;
endmodule

// File: tb/hbus_front_bench.sv
`timescale 1ns/1ps
module hbus_front_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_common = 1'b0, ale = 1'b0, rd_n = 1'b1, wr_n = 1'b1, cs_n = 1'b1;
  logic [2:0] a = 3'd0;
  logic [7:0] din = 8'd0;
  logic [7:0] data_o, reg_wdata, reg_rdata;
  logic data_oe, wait_o, wait_oe, mode_valid, reg_we, reg_re;
  logic [2:0] mode_o;
  logic [5:0] reg_addr;

  int errors = 0, checks = 0;
  int we_cnt = 0, re_cnt = 0;
  logic [5:0] last_waddr = '0;
  logic [7:0] last_wdata = '0;
  logic [7:0] regs [64] = '{default: 8'h00};
  bit finished = 0;

  always #2.5 clk = ~clk;

  hbus_front u_hbus_front (
    .clk(clk), .rst(rst), .cfg_common(cfg_common), .ale_i(ale), .a_i(a),
    .rd_n_i(rd_n), .wr_n_i(wr_n), .cs_n_i(cs_n), .din(din),
    .data_o(data_o), .data_oe(data_oe), .wait_o(wait_o), .wait_oe(wait_oe),
    .mode_o(mode_o), .mode_valid(mode_valid), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_re(reg_re),
    .reg_rdata(reg_rdata)
  );

  assign reg_rdata = regs[reg_addr];

  always @(posedge clk) begin
    if (reg_we) begin
      regs[reg_addr] <= reg_wdata;
      we_cnt <= we_cnt + 1;
      last_waddr <= reg_addr;
      last_wdata <= reg_wdata;
    end
    if (reg_re) re_cnt <= re_cnt + 1;
  end

  // detection vectors: {cfg, ale, a[2:0], cs_n, expected mode[2:0]}
  localparam logic [8:0] DET_TAB [8] = '{
    {1'b0, 1'b1, 3'b000, 1'b1, 3'd1},
    {1'b1, 1'b1, 3'b000, 1'b1, 3'd3},
    {1'b0, 1'b0, 3'b011, 1'b1, 3'd2},
    {1'b0, 1'b0, 3'b010, 1'b1, 3'd4},
    {1'b0, 1'b1, 3'b110, 1'b0, 3'd5},
    {1'b0, 1'b0, 3'b111, 1'b0, 3'd5},
    {1'b0, 1'b0, 3'b000, 1'b1, 3'd0},
    {1'b1, 1'b0, 3'b110, 1'b1, 3'd0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic go_mode(input logic c, input logic l, input logic [2:0] ad, input logic cs);
    cfg_common = c; ale = l; a = ad; cs_n = cs; rd_n = 1; wr_n = 1; din = 0;
    rst = 1; idle(4); rst = 0; idle(14);
  endtask

  task automatic mux_addr(input logic [7:0] ad);
    ale = 1; din = ad; idle(4); ale = 0; idle(4);
  endtask

  task automatic sep_wr(input logic [7:0] d);
    din = d; cs_n = 0; wr_n = 0; idle(6); wr_n = 1; cs_n = 1; idle(6);
  endtask

  task automatic sep_rd(input string req, input logic [7:0] exp);
    cs_n = 0; rd_n = 0; idle(8);
    chk(req, data_oe, 1); chk(req, data_o, exp);
    rd_n = 1; cs_n = 1; idle(6);
    chk(req, data_oe, 0);
  endtask

  task automatic com_xfer(input string req, input bit wr, input logic [7:0] d);
    wr_n = ~wr; din = d; idle(2); cs_n = 0; rd_n = 0; idle(8);
    if (!wr) begin chk(req, data_oe, 1); chk(req, data_o, d); end
    rd_n = 1; cs_n = 1; idle(6); wr_n = 1;
  endtask

  task automatic epp_addr(input bit rd, input logic [7:0] ad);
    wr_n = rd; din = ad; idle(2); ale = 0; idle(6);
    chk("R10 wait during address strobe", wait_o, 1);
    ale = 1; idle(6);
    chk("R10 wait released", wait_o, 0);
    wr_n = 1;
  endtask

  task automatic epp_data(input bit wr, input logic [7:0] d, input bit exp_wait);
    wr_n = ~wr; din = d; idle(2); rd_n = 0; idle(6);
    chk("R10 wait during data strobe", wait_o, exp_wait);
    if (!wr && exp_wait) chk("R9 EPP read data", data_o, d);
    rd_n = 1; idle(6); wr_n = 1;
  endtask

  initial begin
    int w0, r0;
    // R1 reset state
    idle(3);
    chk("R1 reg_we in reset", reg_we, 0);
    chk("R1 reg_re in reset", reg_re, 0);
    chk("R1 data_oe in reset", data_oe, 0);
    chk("R1 wait_oe in reset", wait_oe, 0);
    chk("R1 mode_valid in reset", mode_valid, 0);
    rst = 0; idle(3);
    chk("R1 mode_valid before detect", mode_valid, 0);

    // R2 detection table
    foreach (DET_TAB[i]) begin
      go_mode(DET_TAB[i][8], DET_TAB[i][7], DET_TAB[i][6:4], DET_TAB[i][3]);
      chk("R2 mode code", mode_o, DET_TAB[i][2:0]);
      chk("R2 mode_valid", mode_valid, DET_TAB[i][2:0] != 3'd0);
    end

    // R2 unrecognised mode issues nothing
    go_mode(0, 0, 3'b000, 1);
    w0 = we_cnt; sep_wr(8'h44);
    chk("R2 no access when unrecognised", we_cnt, w0);

    // separate strobes, multiplexed
    go_mode(0, 0, 3'b011, 1);
    w0 = we_cnt;
    mux_addr(8'h2A); sep_wr(8'h5C);
    chk("R3 one write pulse", we_cnt, w0 + 1);
    chk("R6 latched mux address", last_waddr, 6'h2A);
    chk("R3 write data", last_wdata, 8'h5C);
    r0 = re_cnt;
    sep_rd("R4 separate read", 8'h5C);
    chk("R11 one read pulse", re_cnt, r0 + 1);
    w0 = we_cnt;
    din = 8'hEE; wr_n = 0; idle(6); wr_n = 1; idle(6);
    chk("R7 cs high blocks write", we_cnt, w0);
    a = 3'b111; cs_n = 0; ale = 1; idle(12);
    chk("R12 mode held after pin change", mode_o, 3'd2);
    chk("R12 valid held", mode_valid, 1);
    cs_n = 1; ale = 0;

    // separate strobes, dedicated address
    go_mode(0, 1, 3'b000, 1);
    a = 3'd5; sep_wr(8'h33);
    chk("R6 dedicated address", last_waddr, 6'h05);
    chk("R3 dedicated write data", last_wdata, 8'h33);

    // common strobe, multiplexed
    go_mode(0, 0, 3'b010, 1);
    w0 = we_cnt;
    mux_addr(8'h11); com_xfer("R5 common write", 1, 8'h77);
    chk("R5 common write pulse", we_cnt, w0 + 1);
    chk("R5 common write address", last_waddr, 6'h11);
    chk("R5 common write data", last_wdata, 8'h77);
    com_xfer("R5 common read back", 0, 8'h77);

    // common strobe, dedicated address
    go_mode(1, 1, 3'b000, 1);
    a = 3'd5; com_xfer("R5 dedicated common read", 0, 8'h33);

    // EPP
    go_mode(0, 1, 3'b110, 0);
    chk("R10 wait undriven after detect", wait_oe, 0);
    w0 = we_cnt;
    epp_data(1, 8'h99, 1);
    chk("R9 EPP write address", last_waddr, 6'h00);
    chk("R9 EPP write data", last_wdata, 8'h99);
    chk("R10 still undriven before address strobe", wait_oe, 0);
    epp_addr(0, 8'h3C);
    chk("R10 driven after address strobe", wait_oe, 1);
    epp_addr(1, 8'h01);
    epp_data(1, 8'hA5, 1);
    chk("R8 address read ignored", last_waddr, 6'h3C);
    chk("R9 EPP write data 2", last_wdata, 8'hA5);
    chk("R11 EPP write count", we_cnt, w0 + 2);
    r0 = re_cnt;
    epp_data(0, 8'hA5, 1);
    chk("R9 EPP read pulse", re_cnt, r0 + 1);
    cs_n = 1; w0 = we_cnt;
    epp_data(1, 8'h12, 0);
    chk("R7 cs gates EPP data strobe", we_cnt, w0);
    chk("R10 wait_oe kept", wait_oe, 1);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog R11 actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule